// File: doc/BRIEF.md
# Bidirectional Staged Barrel Shifter

This combinational unit shifts a 32-bit operand by an unsigned amount from 0 to 31 in one of three ways: logical left, logical right or arithmetic right. There is one left-shift core. It is a cascade of power-of-two stages (16, 8, 4, 2, 1), and each stage is enabled by one bit of the amount. The core fills the low positions it vacates with a programmable fill bit.

Right shifts use the same core. The operand is bit-reversed before the core and the core result is reversed again afterward. The fill bit is zero for logical shifts and the operand's sign bit for the arithmetic right shift. The unit has no clock and no reset, and its result follows its inputs within the same evaluation.

It is intended as the shift path of an integer datapath. A decoder drives the 2-bit mode and the amount, and the result is consumed directly.

Top module: `barrel_shift32`

## Requirements
- R1: With mode 2'b00, res equals opnd shifted left by amt, and the vacated low amt bits are 0.
- R2: Mode 2'b11 behaves exactly like mode 2'b00 (logical left) for every operand and amount.
- R3: With mode 2'b01, res equals opnd shifted right by amt, and the vacated high amt bits are 0.
- R4: With mode 2'b10, res equals opnd shifted right by amt, and the vacated high amt bits are copies of opnd[31].
- R5: With amt equal to 0, res equals opnd in every mode.
- R6: At the maximum amount 31, a left shift leaves opnd[0] in res[31] with all other bits 0. A logical right shift leaves opnd[31] in res[0] with all other bits 0. An arithmetic right shift yields 32 copies of opnd[31].
- R7: The unit is combinational: a change on any input appears on res without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd | input | 32 | Operand to be shifted |
| amt | input | 5 | Unsigned shift amount, 0 to 31 |
| mode | input | 2 | 00/11 logical left, 01 logical right, 10 arithmetic right |
| res | output | 32 | Shifted result |

## Verification
The case hardest to bring about is an arithmetic right shift of a negative operand by a large amount, together with the unused mode code 11 at the extreme amounts. Only in that case does the fill bit differ from zero, and every reversed stage contributes fill. Uniform random operands produce negative values only half the time and produce a given amount rarely. For this reason, directed vectors fix opnd[31] to 1 and sweep every amount in every mode, including 11, before the seeded random phase runs.

// File: rtl/barrel_shift32.sv
module barrel_shift32 #(
  parameter int WIDTH = 32,
  localparam int AW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opnd,
  input  logic [AW-1:0]    amt,
  input  logic [1:0]       mode,
  output logic [WIDTH-1:0] res
);

  function automatic logic [WIDTH-1:0] flip(input logic [WIDTH-1:0] v);
    for (int i = 0; i < WIDTH; i++) flip[i] = v[WIDTH-1-i];
  endfunction

  logic             go_right;
  logic             fill;
  logic [WIDTH-1:0] stg [AW+1];

  assign go_right = (mode == 2'b01) || (mode == 2'b10);
  assign fill     = (mode == 2'b10) & opnd[WIDTH-1];
  assign stg[0]   = go_right ? flip(opnd) : opnd;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int SH = 1 << (AW - 1 - k);
    assign stg[k+1] = amt[AW-1-k] ? {stg[k][WIDTH-1-SH:0], {SH{fill}}} : stg[k];
  end

  assign res = go_right ? flip(stg[AW]) : stg[AW];

  always_comb begin
    AST_ZERO_AMT_PASS: assert (amt != '0 || res == opnd); // R5
    AST_LEFT_LOW_CLEAR: assert (go_right || (res & ~({WIDTH{1'b1}} << amt)) == '0); // R1
    AST_LSR_HIGH_CLEAR: assert (mode != 2'b01 || (res & ~({WIDTH{1'b1}} >> amt)) == '0); // R3
    AST_ASR_SIGN_KEPT: assert (mode != 2'b10 || res[WIDTH-1] == opnd[WIDTH-1]); // R4
  end

endmodule

// File: tb/barrel_shift32_test.sv
module barrel_shift32_test;
  logic        clk = 1'b0;
  logic [31:0] opnd;
  logic [4:0]  amt;
  logic [1:0]  mode;
  logic [31:0] res;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  barrel_shift32 uut (.opnd(opnd), .amt(amt), .mode(mode), .res(res));

  function automatic logic [31:0] model(input logic [31:0] b, input logic [4:0] a,
                                        input logic [1:0] m);
    case (m)
      2'b01:   model = b >> a;
      2'b10:   model = 32'($signed(b) >>> a);
      default: model = b << a;
    endcase
  endfunction

  function automatic string tag(input logic [1:0] m, input logic [4:0] a);
    if (a == 0) return "R5";
    if (a == 31) return "R6";
    case (m)
      2'b00:   return "R1";
      2'b11:   return "R2";
      2'b01:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic apply(input logic [31:0] b, input logic [4:0] a, input logic [1:0] m);
    logic [31:0] e;
    @(negedge clk);
    opnd = b; amt = a; mode = m;
    #1;
    e = model(b, a, m);
    checks++;
    if (res !== e) begin
      failures++;
      $display("FAIL %s mode=%b amt=%0d opnd=%h actual=%h expected=%h",
               tag(m, a), m, a, b, res, e);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250));
    apply(32'h0, 5'd0, 2'b00);
    // R5: zero amount in every mode
    for (int m = 0; m < 4; m++) apply(32'h9ABC_DEF1, 5'd0, 2'(m));
    // R6: maximum amount with both operand edge bits set
    for (int m = 0; m < 4; m++) apply(32'h8000_0001, 5'd31, 2'(m));
    // R4, R2: negative operand swept over every amount in every mode
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 32; a++) apply(32'hC3A5_0F17, 5'(a), 2'(m));
    // R1, R3: positive operand sweep
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 32; a++) apply(32'h7FFF_FFFF, 5'(a), 2'(m));
    // R7: input change without a clock edge must show on res
    opnd = 32'h0000_00F0; amt = 5'd4; mode = 2'b01;
    #1;
    checks++;
    if (res !== 32'h0000_000F) begin
      failures++;
      $display("FAIL R7 actual=%h expected=%h", res, 32'h0000_000F);
    end
    mode = 2'b00;
    #1;
    checks++;
    if (res !== 32'h0000_0F00) begin
      failures++;
      $display("FAIL R7 actual=%h expected=%h", res, 32'h0000_0F00);
    end
    for (int i = 0; i < 3000; i++)
      apply($urandom, 5'($urandom), 2'($urandom));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule